// File: doc/BRIEF.md
# Half-Integer Clock Divider

This block derives a slower clock from a source clock at a ratio of N + 0.5, where N is picked at run time from 1 up to a parameterised maximum (3 by default). A modulo-(2N+1) counter defines a window of 2N+1 source cycles. Each window holds exactly two output periods of identical length. One pulse register runs on the rising source edge and a second on the falling source edge. Their outputs are ORed, so the uneven spacing of either train alone becomes a uniform output period.

The duty cycle cannot be exactly 50%. For N of 2 or more, each output pulse lasts one and a half source cycles. For N = 1 that width would fill the whole period, so the block switches to a narrow pattern with one-cycle pulses. The ratio select is taken up only at the start of a window, so a new ratio never cuts an output period short.

Top module: `halfint_clkdiv`

## Requirements
- R1: While `rst_n` is low, `clk_out` is low, and the reset acts without waiting for a clock edge. The first rising edge of `clk_src` after release starts a window, and `clk_out` rises at that edge.
- R2: A window lasts 2N+1 source cycles and contains exactly two rising edges of `clk_out`.
- R3: For N >= 2, `clk_out` is high for 1.5 source cycles from the window start. It is high again for 1.5 source cycles starting N + 0.5 source cycles after the window start, and low at all other times.
- R4: For N = 1, `clk_out` is high for one source cycle from the window start and for one source cycle starting 1.5 source cycles after it. It is low in the remaining half cycle of each half window.
- R5: Successive rising edges of `clk_out` are spaced exactly N + 0.5 source periods apart. N is the ratio of the window in which the earlier edge lies.
- R6: `ratio_sel` is sampled only at the rising source edge that starts a window. A change in the middle of a window has no effect on `clk_out` until the next window starts.
- R7: `ratio_sel` holds N as an unsigned binary number. The value 0 is treated as 1, and values above MAX_N are treated as MAX_N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Source clock; both edges are used |
| rst_n | input | 1 | Active-low asynchronous reset |
| ratio_sel | input | SEL_W | Requested N; divide ratio is N + 0.5 |
| clk_out | output | 1 | Divided clock |

## Verification
A wrong count or a wrong decode shows at the ports within one window. It appears as a pulse shifted by half a source cycle, a missing pulse, or two pulses merged into one. The half-cycle reference model then reports it at the next quarter-cycle sample. If the ratio is taken up at the wrong moment, the interval that straddles a window boundary changes length. That interval is measured directly after every change of select. A falling-edge register that fails to reset or stalls shows as a rising edge of `clk_out` half a cycle early or late.

// File: rtl/hdiv_pkg.sv
package hdiv_pkg;

   // Maps a raw select value onto the legal range 1..max_n.
   function automatic int unsigned fit_ratio(input int unsigned raw, input int unsigned max_n);
      if (raw == 0)
         return 1;
      else if (raw > max_n)
         return max_n;
      else
         return raw;
   endfunction

endpackage

// File: rtl/hdiv_ratio_reg.sv
module hdiv_ratio_reg #(
   parameter int unsigned MAX_N = 3,
   parameter int unsigned SEL_W = 2,
   parameter int unsigned NW    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [SEL_W-1:0] sel,
   output logic [NW-1:0]    n_q
);
   import hdiv_pkg::*;

   logic [NW-1:0] n_fit;

   always_comb begin
      n_fit = NW'(fit_ratio(32'(sel), MAX_N));
   end

   // Zero after reset means "no ratio taken yet"; the counter wraps at once.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         n_q <= '0;
      else if (load)
         n_q <= n_fit;
   end

   a_r6_ratio_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(n_q));

   a_r7_ratio_legal : assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (n_q >= NW'(1)) && (n_q <= NW'(MAX_N)));

endmodule

// File: rtl/hdiv_counter.sv
module hdiv_counter #(
   parameter int unsigned NW = 2,
   parameter int unsigned CW = NW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NW-1:0] n_q,
   output logic [CW-1:0] cnt_q,
   output logic [CW-1:0] cnt_nxt,
   output logic          wrap
);
   logic [CW-1:0] last;

   always_comb begin
      last    = CW'({n_q, 1'b0});
      wrap    = (cnt_q >= last);
      cnt_nxt = wrap ? '0 : cnt_q + CW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else
         cnt_q <= cnt_nxt;
   end

   a_r2_count_bound : assert property (@(posedge clk) disable iff (!rst_n)
      (n_q != '0) |-> (cnt_q <= CW'({n_q, 1'b0})));

endmodule

// File: rtl/hdiv_pulse.sv
module hdiv_pulse #(
   parameter bit ON_FALL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   output logic pulse_q
);
   generate
      if (ON_FALL) begin : g_fall
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n)
               pulse_q <= 1'b0;
            else
               pulse_q <= hit;
         end

         a_r3_fall_single : assert property (@(negedge clk) disable iff (!rst_n)
            pulse_q |=> !pulse_q);
      end else begin : g_rise
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pulse_q <= 1'b0;
            else
               pulse_q <= hit;
         end

         a_r3_rise_single : assert property (@(posedge clk) disable iff (!rst_n)
            pulse_q |=> !pulse_q);
      end
   endgenerate

endmodule

// File: rtl/halfint_clkdiv.sv
module halfint_clkdiv #(
   parameter int unsigned MAX_N = 3,
   parameter int unsigned SEL_W = 2
) (
   input  logic             clk_src,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] ratio_sel,
   output logic             clk_out
);
   localparam int unsigned NW = $clog2(MAX_N + 1);
   localparam int unsigned CW = NW + 1;

   generate
      if (MAX_N < 1) begin : g_bad_max
         $error("MAX_N must be at least 1");
      end
      if (SEL_W < NW) begin : g_bad_sel
         $error("SEL_W too narrow for MAX_N");
      end
   endgenerate

   logic [NW-1:0] n_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_nxt;
   logic          wrap;
   logic          wide;
   logic          rise_hit;
   logic          fall_hit;
   logic          rise_q;
   logic          fall_q;

   hdiv_ratio_reg #(.MAX_N(MAX_N), .SEL_W(SEL_W), .NW(NW)) u_ratio (
      .clk   (clk_src),
      .rst_n (rst_n),
      .load  (wrap),
      .sel   (ratio_sel),
      .n_q   (n_q)
   );

   hdiv_counter #(.NW(NW), .CW(CW)) u_cnt (
      .clk     (clk_src),
      .rst_n   (rst_n),
      .n_q     (n_q),
      .cnt_q   (cnt_q),
      .cnt_nxt (cnt_nxt),
      .wrap    (wrap)
   );

   // Wide pattern: two pulses per train. Narrow pattern (N=1): one per train.
   always_comb begin
      wide     = (n_q >= NW'(2));
      rise_hit = wrap || (wide && (cnt_nxt == CW'(n_q) + CW'(1)));
      fall_hit = (n_q != '0) &&
                 ((cnt_q == CW'(n_q)) || (wide && (cnt_q == '0)));
   end

   hdiv_pulse #(.ON_FALL(1'b0)) u_rise (
      .clk     (clk_src),
      .rst_n   (rst_n),
      .hit     (rise_hit),
      .pulse_q (rise_q)
   );

   hdiv_pulse #(.ON_FALL(1'b1)) u_fall (
      .clk     (clk_src),
      .rst_n   (rst_n),
      .hit     (fall_hit),
      .pulse_q (fall_q)
   );

   assign clk_out = rise_q | fall_q;

endmodule

// File: tb/sim_halfint_clkdiv.sv
`timescale 1ns/1ps
module sim_halfint_clkdiv;
   localparam int MAX_N = 3;
   localparam real TP  = 10.0;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] sel = 2'd3;
   logic       clk_out;

   int n_checks = 0;
   int n_fail   = 0;

   // Reference model state: half-cycle index within the window and the window ratio
   int  h = 0;
   int  n_cur = 1;
   bit  started = 1'b0;
   bit  have_prev = 1'b0;
   realtime t_prev = 0.0;
   int  n_prev = 1;

   halfint_clkdiv #(.MAX_N(MAX_N), .SEL_W(2)) u0 (
      .clk_src   (clk),
      .rst_n     (rst_n),
      .ratio_sel (sel),
      .clk_out   (clk_out)
   );

   always #5 clk = ~clk;

   function automatic int clamp(input int v);
      if (v < 1) return 1;
      if (v > MAX_N) return MAX_N;
      return v;
   endfunction

   function automatic logic expect_out();
      if (!started) return 1'b0;
      if (n_cur == 1) return (h < 2) || (h >= 3 && h < 5);
      return (h < 3) || (h >= 2 * n_cur + 1 && h < 2 * n_cur + 4);
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input real act, input real exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0.3f expected %0.3f at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic sample_cmp();
      logic e;
      e = expect_out();
      chk(clk_out === e, (started && n_cur == 1) ? "R4" : "R3", "clk_out level",
          real'(clk_out), real'(e));
   endtask

   always @(negedge rst_n) begin
      started   = 1'b0;
      have_prev = 1'b0;
   end

   always @(posedge clk) begin
      if (rst_n) begin
         if (!started || h == 2 * (2 * n_cur + 1) - 1) begin
            n_cur   = clamp(int'(sel));
            h       = 0;
            started = 1'b1;
         end else begin
            h++;
         end
      end
      #2 sample_cmp();
   end

   always @(negedge clk) begin
      if (started) h++;
      #2 sample_cmp();
   end

   // R5: spacing of successive output rising edges
   always @(posedge clk_out) begin
      realtime t_now;
      t_now = $realtime;
      #1;
      if (have_prev)
         chk(($realtime - 1.0 - t_prev) == 0.0 ? 1'b0 :
             (((t_now - t_prev) - (n_prev * TP + TP / 2.0)) < 0.01 &&
              ((t_now - t_prev) - (n_prev * TP + TP / 2.0)) > -0.01),
             "R5", "rise spacing ns", t_now - t_prev, n_prev * TP + TP / 2.0);
      if (rst_n && started) begin
         have_prev = 1'b1;
         t_prev    = t_now;
         n_prev    = n_cur;
      end
   end

   task automatic wait_window_start();
      do begin
         @(posedge clk_out);
         #1;
      end while (h != 0);
   endtask

   task automatic measure(output real d);
      realtime a;
      @(posedge clk_out);
      a = $realtime;
      @(posedge clk_out);
      d = $realtime - a;
   endtask

   initial begin
      #300000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      real d;
      int  rises;
      // R1: reset state
      #12;
      chk(clk_out === 1'b0, "R1", "clk_out in reset", real'(clk_out), 0.0);
      @(negedge clk); #1 rst_n = 1'b1;
      @(posedge clk); #2;
      chk(clk_out === 1'b1, "R1", "first edge after release", real'(clk_out), 1.0);

      repeat (30) @(posedge clk);

      // R2: two output rises per window of 2N+1 cycles (N=3)
      @(posedge clk); #1;
      rises = 0;
      fork
         begin : cnt_blk
            forever begin @(posedge clk_out); rises++; end
         end
         begin
            #(3 * 7 * 10);
            disable cnt_blk;
         end
      join
      chk(rises == 6, "R2", "rises in three windows", real'(rises), 6.0);

      // R6: change mid-window; the running window keeps the old ratio
      wait_window_start();
      sel = 2'd2;
      measure(d);
      chk(d > 34.99 && d < 35.01, "R6", "interval after mid-window change", d, 35.0);
      measure(d);
      chk(d > 24.99 && d < 25.01, "R6", "interval in new window", d, 25.0);

      repeat (20) @(posedge clk);

      // R4: narrow pattern at N=1
      wait_window_start();
      sel = 2'd1;
      measure(d);
      chk(d > 24.99 && d < 25.01, "R6", "old ratio kept", d, 25.0);
      measure(d);
      chk(d > 14.99 && d < 15.01, "R4", "interval at N=1", d, 15.0);
      repeat (20) @(posedge clk);

      // R7: select 0 behaves as 1
      wait_window_start();
      sel = 2'd3;
      repeat (20) @(posedge clk);
      wait_window_start();
      sel = 2'd0;
      measure(d);
      measure(d);
      chk(d > 14.99 && d < 15.01, "R7", "select 0 interval", d, 15.0);
      repeat (20) @(posedge clk);

      // R1: asynchronous reset in mid-run
      sel = 2'd2;
      repeat (15) @(posedge clk);
      wait_window_start();
      #2 rst_n = 1'b0;
      #1;
      chk(clk_out === 1'b0, "R1", "clk_out right after async reset", real'(clk_out), 0.0);
      repeat (3) @(posedge clk);
      @(negedge clk); #1 rst_n = 1'b1;
      @(posedge clk); #2;
      chk(clk_out === 1'b1, "R1", "restart edge", real'(clk_out), 1.0);
      repeat (40) @(posedge clk);

      #3;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule